// File: doc/BRIEF.md
# Hamming Syndrome Corrector

This block checks the Hamming code read back from the spare area of a flash sector. It takes the 24-bit code computed over a 512-byte sector and the 24-bit code stored with that sector, each as three bytes. On a start strobe it combines them into a syndrome and sorts the result into one of four classes. When exactly one data bit is wrong, it also gives the byte index and the bit index that must be inverted to repair the sector.

The result is registered. It appears, together with a one-cycle done pulse, on the clock edge after start. It then stays on the outputs until the next start. A start may be given on every cycle, and each one produces its own result.

A small two-state machine sequences the block. The states are `ST_IDLE`, where no result is being announced, and `ST_REPORT`, where done is high. The transitions are:
- `IDLE->REPORT` on start.
- `REPORT->REPORT` on a further start.
- `REPORT->IDLE` when start is low.
- `IDLE->IDLE` when start is low.

Top module: `hecc_corrector`

## Requirements
- R1: When the calculated and stored codes are equal (zero syndrome), status is 2'b00 (none) one clock after start.
- R2: The syndrome is calc XOR stored, bit for bit. Byte 0 of each code is bits 7:0, byte 1 is bits 15:8 and byte 2 is bits 23:16. A syndrome with exactly 12 ones gives status 2'b01 (corrected).
- R3: A syndrome with between 1 and 22 ones, other than 12, gives status 2'b10 (uncorrectable).
- R4: A syndrome with 23 or 24 ones gives status 2'b11 (code error).
- R5: When status is corrected, bit_addr bits 0, 1 and 2 equal syndrome bits 1, 3 and 5.
- R6: When status is corrected, byte_addr bits 0 to 8 equal syndrome bits 7, 9, 11, 13, 15, 17, 19, 21 and 23.
- R7: When status is not corrected, byte_addr and bit_addr are zero.
- R8: done is high for exactly the cycles that follow a cycle with start high. It is low in every other cycle.
- R9: status, byte_addr and bit_addr keep their values in cycles without done, whatever the code inputs do.
- R10: After reset, done is 0, status is 2'b00 and both addresses are 0.
- R11: Starts on consecutive cycles each give their own result, one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Evaluate the codes presented in this cycle |
| calc_code | input | 24 | Code computed over the sector data |
| stored_code | input | 24 | Code read from the spare area |
| done | output | 1 | One-cycle pulse: a new result is on the outputs |
| status | output | 2 | 00 none, 01 corrected, 10 uncorrectable, 11 code error |
| byte_addr | output | 9 | Index of the byte to repair |
| bit_addr | output | 3 | Index of the bit to repair within that byte |

## Verification
Two events can fall in the same cycle: a result is announced with done, and a new start captures fresh codes. If the start overwrites the result registers a cycle early, or the machine leaves `ST_REPORT` at the wrong time, results are lost.

The bench provokes this by sweeping all 4096 single-bit repair locations with start held high on every cycle. Each location's syndrome has the location in its odd bits and the inverse in its even bits. The bench requires each result, address and done pulse to match the start one cycle earlier.

The isolated sweep over every population count shows the other side: done falls and the outputs hold once start goes low.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

    typedef enum logic [1:0] {
        HS_NONE    = 2'b00,
        HS_CORR    = 2'b01,
        HS_UNCORR  = 2'b10,
        HS_CODEERR = 2'b11
    } hecc_status_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } hecc_state_e;

    localparam int unsigned HECC_BIT_W = 3;

endpackage

// File: rtl/hecc_syndrome.sv
module hecc_syndrome #(
    parameter int unsigned SYN_W = 24,
    parameter int unsigned CNT_W = $clog2(SYN_W + 1)
) (
    input  logic [SYN_W-1:0]   calc_code,
    input  logic [SYN_W-1:0]   stored_code,
    output logic [CNT_W-1:0]   ones,
    output logic [SYN_W/2-1:0] odd_bits
);
    localparam int unsigned HALF = SYN_W / 2;

    logic [SYN_W-1:0] syn;

    assign syn = calc_code ^ stored_code;

    always_comb begin
        ones = '0;
        for (int i = 0; i < SYN_W; i++) begin
            ones = ones + {{(CNT_W-1){1'b0}}, syn[i]};
        end
    end

    for (genvar k = 0; k < HALF; k++) begin : g_odd
        assign odd_bits[k] = syn[2*k+1];
    end

endmodule

// File: rtl/hecc_classify.sv
module hecc_classify
    import hecc_pkg::*;
#(
    parameter int unsigned SYN_W = 24,
    parameter int unsigned CNT_W = $clog2(SYN_W + 1)
) (
    input  logic [CNT_W-1:0] ones,
    output hecc_status_e     verdict
);
    localparam logic [CNT_W-1:0] SINGLE_ONES = CNT_W'(SYN_W / 2);
    localparam logic [CNT_W-1:0] BROKEN_MIN  = CNT_W'(SYN_W - 1);

    always_comb begin
        if (ones == '0)               verdict = HS_NONE;
        else if (ones >= BROKEN_MIN)  verdict = HS_CODEERR;
        else if (ones == SINGLE_ONES) verdict = HS_CORR;
        else                          verdict = HS_UNCORR;
    end

endmodule

// File: rtl/hecc_locate.sv
module hecc_locate #(
    parameter int unsigned SYN_W  = 24,
    parameter int unsigned BIT_W  = 3,
    parameter int unsigned BYTE_W = SYN_W / 2 - BIT_W
) (
    input  logic [SYN_W/2-1:0] odd_bits,
    input  logic               repairable,
    output logic [BYTE_W-1:0]  byte_idx,
    output logic [BIT_W-1:0]   bit_idx
);
    always_comb begin
        if (repairable) begin
            bit_idx  = odd_bits[BIT_W-1:0];
            byte_idx = odd_bits[SYN_W/2-1:BIT_W];
        end else begin
            bit_idx  = '0;
            byte_idx = '0;
        end
    end

endmodule

// File: rtl/hecc_corrector.sv
module hecc_corrector
    import hecc_pkg::*;
#(
    parameter int unsigned CODE_BYTES = 3,
    parameter int unsigned SYN_W      = 8 * CODE_BYTES,
    parameter int unsigned BYTE_W     = SYN_W / 2 - HECC_BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SYN_W-1:0]  calc_code,
    input  logic [SYN_W-1:0]  stored_code,
    output logic              done,
    output logic [1:0]        status,
    output logic [BYTE_W-1:0] byte_addr,
    output logic [HECC_BIT_W-1:0] bit_addr
);
    localparam int unsigned CNT_W = $clog2(SYN_W + 1);
    localparam int unsigned HALF  = SYN_W / 2;

    hecc_state_e           state_q, state_d;
    logic [CNT_W-1:0]      ones;
    logic [HALF-1:0]       odd_bits;
    hecc_status_e          verdict;
    logic [BYTE_W-1:0]     byte_nx;
    logic [HECC_BIT_W-1:0] bit_nx;
    hecc_status_e          status_q;

    hecc_syndrome #(.SYN_W(SYN_W), .CNT_W(CNT_W)) u_syn (
        .calc_code   (calc_code),
        .stored_code (stored_code),
        .ones        (ones),
        .odd_bits    (odd_bits)
    );

    hecc_classify #(.SYN_W(SYN_W), .CNT_W(CNT_W)) u_cls (
        .ones    (ones),
        .verdict (verdict)
    );

    hecc_locate #(.SYN_W(SYN_W), .BIT_W(HECC_BIT_W), .BYTE_W(BYTE_W)) u_loc (
        .odd_bits   (odd_bits),
        .repairable (verdict == HS_CORR),
        .byte_idx   (byte_nx),
        .bit_idx    (bit_nx)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = start ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = start ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q  <= HS_NONE;
            byte_addr <= '0;
            bit_addr  <= '0;
        end else if (start) begin
            status_q  <= verdict;
            byte_addr <= byte_nx;
            bit_addr  <= bit_nx;
        end
    end

    assign done   = (state_q == ST_REPORT);
    assign status = status_q;

endmodule

// File: rtl/hecc_corrector_chk.sv
module hecc_corrector_chk #(
    parameter int unsigned SYN_W  = 24,
    parameter int unsigned BYTE_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [SYN_W-1:0]  calc_code,
    input logic [SYN_W-1:0]  stored_code,
    input logic              done,
    input logic [1:0]        status,
    input logic [BYTE_W-1:0] byte_addr,
    input logic [2:0]        bit_addr
);
    logic [SYN_W-1:0] x_syn;
    assign x_syn = calc_code ^ stored_code;

    // R8
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R8
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R1
    zero_syndrome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && calc_code == stored_code) |=> status == 2'b00);

    // R2
    single_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && $countones(x_syn) == SYN_W/2) |=> status == 2'b01);

    // R4
    code_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && $countones(x_syn) >= SYN_W-1) |=> status == 2'b11);

    // R5
    bit_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && $countones(x_syn) == SYN_W/2) |=>
        bit_addr == $past({x_syn[5], x_syn[3], x_syn[1]}));

    // R7
    addr_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != 2'b01) |-> (byte_addr == '0 && bit_addr == '0));

    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(status) && $stable(byte_addr) && $stable(bit_addr)));

endmodule

bind hecc_corrector hecc_corrector_chk #(.SYN_W(SYN_W), .BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .calc_code   (calc_code),
    .stored_code (stored_code),
    .done        (done),
    .status      (status),
    .byte_addr   (byte_addr),
    .bit_addr    (bit_addr)
);

// File: tb/tb_hecc_corrector.sv
module tb_hecc_corrector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] calc_code = '0;
    logic [23:0] stored_code = '0;
    logic        done;
    logic [1:0]  status;
    logic [8:0]  byte_addr;
    logic [2:0]  bit_addr;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int seed   = 1;

    always #10 clk = ~clk;

    hecc_corrector dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .calc_code   (calc_code),
        .stored_code (stored_code),
        .done        (done),
        .status      (status),
        .byte_addr   (byte_addr),
        .bit_addr    (bit_addr)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual %0d expected <150000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [23:0] syn, output logic [1:0] st,
                                  output logic [8:0] by, output logic [2:0] bi);
        int pop = 0;
        for (int i = 0; i < 24; i++) pop += syn[i];
        if (pop == 0)       st = 2'b00;
        else if (pop >= 23) st = 2'b11;
        else if (pop == 12) st = 2'b01;
        else                st = 2'b10;
        by = '0;
        bi = '0;
        if (st == 2'b01) begin
            for (int i = 0; i < 3; i++) bi[i] = syn[2*i+1];
            for (int i = 0; i < 9; i++) by[i] = syn[2*i+7];
        end
    endfunction

    function automatic logic [23:0] next_calc();
        seed = seed + 1;
        return 24'((seed * 32'h9E3779B1) >> 5);
    endfunction

    // Drive one start at the current negedge, check its result one cycle later.
    task automatic issue(input logic [23:0] syn);
        logic [1:0] st;
        logic [8:0] by;
        logic [2:0] bi;
        logic [23:0] c;
        string sreq;
        c = next_calc();
        model(syn, st, by, bi);
        start       = 1'b1;
        calc_code   = c;
        stored_code = c ^ syn;
        @(negedge clk);
        case (st)
            2'b00:   sreq = "R1";
            2'b01:   sreq = "R2";
            2'b10:   sreq = "R3";
            default: sreq = "R4";
        endcase
        chk("R8/R11 done", int'(done), 1);
        chk(sreq, int'(status), int'(st));
        chk((st == 2'b01) ? "R5" : "R7", int'(bit_addr), int'(bi));
        chk((st == 2'b01) ? "R6" : "R7", int'(byte_addr), int'(by));
    endtask

    // Drop start and confirm the result holds while the inputs keep moving.
    task automatic idle(input int n);
        logic [1:0] st0;
        logic [8:0] by0;
        logic [2:0] bi0;
        st0 = status;
        by0 = byte_addr;
        bi0 = bit_addr;
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            calc_code   = next_calc();
            stored_code = next_calc();
            @(negedge clk);
            chk("R8 no done", int'(done), 0);
            chk("R9 hold", int'({st0, by0, bi0}), int'({status, byte_addr, bit_addr}));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset values
        chk("R10 done", int'(done), 0);
        chk("R10 status", int'(status), 0);
        chk("R10 addr", int'({byte_addr, bit_addr}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        idle(2);

        // Every population count, with many rotations of a run of ones.
        for (int k = 0; k <= 24; k++) begin
            for (int r = 0; r < 40; r++) begin
                logic [47:0] m;
                logic [23:0] p;
                m = (48'd1 << k) - 48'd1;
                m = (m << (r % 24)) | (m >> (24 - (r % 24)));
                p = m[23:0] | m[47:24];
                issue(p);
                idle(1);
            end
        end

        // R11: all 4096 single-bit repair locations, start high every cycle.
        for (int loc = 0; loc < 4096; loc++) begin
            logic [23:0] p;
            for (int i = 0; i < 12; i++) begin
                p[2*i+1] = loc[i];
                p[2*i]   = ~loc[i];
            end
            issue(p);
        end
        idle(3);

        // R4 and R3 edges back to back.
        issue(24'hFFFFFF);
        issue(24'h7FFFFF);
        issue(24'h3FFFFF);
        issue(24'h000001);
        idle(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule